// File: doc/BRIEF.md
# Symmetric Filter Pre-Adder

This block sits at the front of a symmetric FIR datapath. It folds two operands into one sum before any coefficient multiply. A symmetric filter can then use one multiplier per pair of mirrored taps instead of one per tap. The forward operand is an earlier sample, read from a delay line of 1 to 16 stages. The reverse operand is either the newest sample or the same delayed sample. An ALU adds the two operands, or subtracts the forward operand from the reverse one. Each operand can be forced to zero on its own.

Two 12-bit registers hold the whole setup, at write-port addresses 0 and 1. Register 0 holds the ALU control: the operation and the two operand gates. Register 1 holds the stream shape: the delay length, even or odd tap count, data reversal and odd-tap interleave mode.

When the tap count is odd, the block counts valid samples through a repeating phase sequence. At the centre-tap phase it forces the reverse operand to zero, so the centre sample is not doubled. Interleave mode adds a second centre phase, one for each interleaved channel.

Top module: `fold_preadder`

## Requirements
- R1: Register 0 sits at address 0 and register 1 at address 1; a write of `cfg_wdata` with `cfg_we` high updates the addressed register. `cfg_rdata` returns, one cycle later, the register selected by `cfg_addr`, with bits 11..3 of register 0 and bits 11..7 of register 1 read as zero. After reset, register 0 reads 0x006 and register 1 reads 0x000.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `out_valid` is low, `out_sum` holds its last value. After reset both outputs are zero.
- R3: Register 0 bit 0 sets the operation: 0 gives A + B and 1 gives B - A. `out_sum` is a 13-bit two's-complement value that holds every result without overflow.
- R4: Register 0 bit 1 gates operand A. When it is 0, A is zero; when it is 1, A is the forward (delayed) sample.
- R5: Register 0 bit 2 gates operand B. When it is 0, B is zero; when it is 1, B is the reverse-path sample.
- R6: Register 1 bits 4..1 hold a code n that sets the delay length L = n + 1, from 1 to 16. The forward sample is the valid sample accepted L valid samples earlier, and it is zero until L samples have been accepted since reset.
- R7: Register 1 bit 6 is active low. When it is 0, reversal is on and the reverse sample is the current input. When it is 1, the reverse sample equals the forward sample.
- R8: When register 1 bit 5 is 1 (odd tap count), a phase counter steps 0..L-1 on each valid sample. The sample accepted at phase L-1 has its reverse operand forced to zero.
- R9: When register 1 bit 0 is 1 and the tap count is odd with L >= 2, the sample at phase L-2 also has its reverse operand forced to zero. With an even tap count, bit 0 has no effect.
- R10: A write to register 1 returns the phase counter to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 12 | Signed input sample |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 1 | Register select: 0 for the ALU control, 1 for the stream shape |
| cfg_wdata | input | 12 | Register write data |
| cfg_rdata | output | 12 | Registered readback of the selected register |
| out_valid | output | 1 | Pre-added result strobe |
| out_sum | output | 13 | Signed pre-added result |

## Verification
The bench feeds full-scale positive and negative samples in both add and subtract modes. These expose any loss of the extra output bit. Streams with delay lengths of 1, 5 and 16 tell a wrong delay-line read index apart from a wrong fill gate. The first L outputs of each stream show whether the zero-fill rule is kept. The bench also runs odd-tap streams with interleave off and on, and an even-tap stream with interleave on. These separate the primary centre phase from the second one. A register 1 write in the middle of a stream moves the centre sample only if the phase restart works.

// File: rtl/fold_pkg.sv
package fold_pkg;
  localparam int LEN_CODE_W = 4;
  localparam int HIST_DEPTH = 1 << LEN_CODE_W;
  localparam int LEN_W      = LEN_CODE_W + 1;
  localparam int CFG0_USED  = 3;
  localparam int CFG1_USED  = 7;
  localparam int CFG0_RESET = 6;

  typedef struct packed {
    logic                  rev_off;
    logic                  tap_odd;
    logic [LEN_CODE_W-1:0] len_code;
    logic                  ileave;
    logic                  pass_b;
    logic                  pass_a;
    logic                  sub_mode;
  } cfg_t;
endpackage

// File: rtl/fold_cfg_regs.sv
module fold_cfg_regs
  import fold_pkg::*;
#(
  parameter int REG_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output cfg_t             cfg,
  output logic             seq_restart
);
  localparam logic [REG_W-1:0] MASK0 = REG_W'((1 << CFG0_USED) - 1);
  localparam logic [REG_W-1:0] MASK1 = REG_W'((1 << CFG1_USED) - 1);
  localparam logic [REG_W-1:0] INIT0 = REG_W'(CFG0_RESET);

  logic [REG_W-1:0] alu_q;
  logic [REG_W-1:0] shape_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alu_q   <= INIT0;
      shape_q <= '0;
      rdata   <= '0;
    end else begin
      if (we && !addr) alu_q   <= wdata & MASK0;
      if (we && addr)  shape_q <= wdata & MASK1;
      rdata <= addr ? shape_q : alu_q;
    end
  end

  assign seq_restart = we & addr;

  always_comb begin
    cfg.sub_mode = alu_q[0];
    cfg.pass_a   = alu_q[1];
    cfg.pass_b   = alu_q[2];
    cfg.ileave   = shape_q[0];
    cfg.len_code = shape_q[LEN_CODE_W:1];
    cfg.tap_odd  = shape_q[LEN_CODE_W+1];
    cfg.rev_off  = shape_q[LEN_CODE_W+2];
  end
endmodule

// File: rtl/fold_history.sv
module fold_history
  import fold_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [LEN_W-1:0]    len,
  input  logic                restart,
  output logic [SAMPLE_W-1:0] fwd_raw,
  output logic [LEN_W-1:0]    phase
);
  localparam int PTR_W = LEN_CODE_W;
  localparam logic [LEN_W-1:0] FULL = LEN_W'(HIST_DEPTH);

  logic [SAMPLE_W-1:0] mem [HIST_DEPTH];
  logic [PTR_W-1:0]    wp;
  logic [LEN_W-1:0]    fill;
  logic [PTR_W-1:0]    rd_idx;

  // sample store, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (in_valid) mem[wp] <= in_sample;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      fill  <= '0;
      phase <= '0;
    end else begin
      if (in_valid) begin
        wp <= wp + PTR_W'(1);
        if (fill != FULL) fill <= fill + LEN_W'(1);
      end
      if (restart)
        phase <= '0;
      else if (in_valid)
        phase <= (phase >= len - LEN_W'(1)) ? '0 : phase + LEN_W'(1);
    end
  end

  // a length of 16 wraps to wp itself: the oldest slot
  assign rd_idx  = wp - len[PTR_W-1:0];
  assign fwd_raw = (fill >= len) ? mem[rd_idx] : '0;
endmodule

// File: rtl/fold_alu.sv
module fold_alu
  import fold_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SAMPLE_W-1:0] fwd_raw,
  input  logic [LEN_W-1:0]    phase,
  input  logic [LEN_W-1:0]    len,
  input  logic                sub_mode,
  input  logic                pass_a,
  input  logic                pass_b,
  input  logic                ileave,
  input  logic                tap_odd,
  input  logic                rev_off,
  output logic                out_valid,
  output logic [SAMPLE_W:0]   out_sum
);
  localparam int SUM_W = SAMPLE_W + 1;

  logic [SAMPLE_W-1:0] rev_src;
  logic                centre;
  logic [SUM_W-1:0]    op_a;
  logic [SUM_W-1:0]    op_b;
  logic [SUM_W-1:0]    sum;

  always_comb begin
    rev_src = rev_off ? fwd_raw : in_sample;
    centre  = tap_odd &&
              ((phase == len - LEN_W'(1)) ||
               (ileave && (len >= LEN_W'(2)) && (phase == len - LEN_W'(2))));
    op_a = pass_a ? {fwd_raw[SAMPLE_W-1], fwd_raw} : '0;
    op_b = (pass_b && !centre) ? {rev_src[SAMPLE_W-1], rev_src} : '0;
    sum  = sub_mode ? (op_b - op_a) : (op_a + op_b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sum <= sum;
    end
  end
endmodule

// File: rtl/fold_preadder.sv
module fold_preadder
  import fold_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int REG_W    = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                cfg_we,
  input  logic                cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  output logic                out_valid,
  output logic [SAMPLE_W:0]   out_sum
);
  cfg_t                cfg;
  logic                restart;
  logic [LEN_W-1:0]    len;
  logic [SAMPLE_W-1:0] fwd_raw;
  logic [LEN_W-1:0]    phase;

  fold_cfg_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg), .seq_restart(restart)
  );

  assign len = {1'b0, cfg.len_code} + LEN_W'(1);

  fold_history #(.SAMPLE_W(SAMPLE_W)) u_hist (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .len(len), .restart(restart), .fwd_raw(fwd_raw), .phase(phase)
  );

  fold_alu #(.SAMPLE_W(SAMPLE_W)) u_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .fwd_raw(fwd_raw), .phase(phase), .len(len),
    .sub_mode(cfg.sub_mode), .pass_a(cfg.pass_a), .pass_b(cfg.pass_b),
    .ileave(cfg.ileave), .tap_odd(cfg.tap_odd), .rev_off(cfg.rev_off),
    .out_valid(out_valid), .out_sum(out_sum)
  );
endmodule

// File: rtl/fold_preadder_chk.sv
module fold_preadder_chk
  import fold_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int REG_W    = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                cfg_addr,
  input logic [REG_W-1:0]    cfg_rdata,
  input logic                out_valid,
  input logic [SAMPLE_W:0]   out_sum,
  input logic                pass_a,
  input logic                pass_b,
  input logic                tap_odd,
  input logic [LEN_W-1:0]    phase,
  input logic [LEN_W-1:0]    len
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_sum)));

  // R1
  shape_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[REG_W-1:CFG1_USED] == '0);

  // R1
  alu_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_addr |=> (cfg_rdata[REG_W-1:CFG0_USED] == '0));

  // R4 R5
  both_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pass_a && !pass_b) |=> (out_sum == '0));

  // R8
  centre_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pass_a && tap_odd && (phase == len - LEN_W'(1))) |=> (out_sum == '0));
endmodule

bind fold_preadder fold_preadder_chk #(.SAMPLE_W(SAMPLE_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_sum(out_sum),
  .pass_a(cfg.pass_a), .pass_b(cfg.pass_b), .tap_odd(cfg.tap_odd),
  .phase(phase), .len(len)
);

// File: tb/fold_preadder_bench.sv
`timescale 1ns/1ps
module fold_preadder_bench;
  localparam int SW = 12;
  localparam int RW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic          cfg_we = 1'b0;
  logic          cfg_addr = 1'b0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [RW-1:0] cfg_rdata;
  logic          out_valid;
  logic [SW:0]   out_sum;

  always #2.5 clk = ~clk;

  fold_preadder #(.SAMPLE_W(SW), .REG_W(RW)) u_fold_preadder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_sum(out_sum)
  );

  int    checks = 0;
  int    fails = 0;
  int    exp_q[$];
  string tag_q[$];
  int    hist[$];
  int    sh0 = 6;
  int    sh1 = 0;
  int    ph = 0;
  int    last_exp = 0;
  bit    done = 1'b0;

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // driver: model the expected result, queue it, then present the sample
  task automatic push_sample(int x, string tag);
    int  len_v;
    int  a_raw;
    int  rsrc;
    int  a;
    int  b;
    bit  centre;
    len_v  = ((sh1 >> 1) & 15) + 1;
    a_raw  = (hist.size() >= len_v) ? hist[len_v-1] : 0;
    rsrc   = ((sh1 & 64) != 0) ? a_raw : x;
    centre = ((sh1 & 32) != 0) &&
             ((ph == len_v - 1) || (((sh1 & 1) != 0) && len_v >= 2 && ph == len_v - 2));
    a = ((sh0 & 2) != 0) ? a_raw : 0;
    b = (((sh0 & 4) != 0) && !centre) ? rsrc : 0;
    exp_q.push_back(((sh0 & 1) != 0) ? (b - a) : (a + b));
    tag_q.push_back(tag);
    hist.push_front(x);
    if (hist.size() > 16) void'(hist.pop_back());
    ph = (ph >= len_v - 1) ? 0 : ph + 1;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = SW'(x);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic cfg_write(int a, int d);
    @(negedge clk);
    in_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = a[0];
    cfg_wdata = RW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 0) sh0 = d & 7;
    else begin
      sh1 = d & 127;
      ph  = 0;
    end
  endtask

  task automatic check_read(int a, int expv, string tag);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_addr = a[0];
    @(posedge clk);
    #1;
    check(cfg_rdata == RW'(expv), tag, int'(cfg_rdata), expv);
  endtask

  // monitor: compare each result against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected out_valid", 1, 0);
        end else begin
          int    e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          check($signed(out_sum) == e, t, int'($signed(out_sum)), e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R2 reset state
    check(out_valid == 1'b0, "R2 reset out_valid", int'(out_valid), 0);
    check(out_sum == '0, "R2 reset out_sum", int'(out_sum), 0);
    // R1 reset values and reserved masking
    check_read(0, 6, "R1 reset reg0");
    check_read(1, 0, "R1 reset reg1");
    cfg_write(0, 'hFFF);
    check_read(0, 7, "R1 reg0 reserved");
    cfg_write(1, 'hFFF);
    check_read(1, 'h7F, "R1 reg1 reserved");
    cfg_write(0, 6);
    cfg_write(1, 0);

    // R3 add with L=1 and reversal on (R7), full-scale values
    push_sample(100, "R3 add");
    push_sample(-50, "R3 add");
    push_sample(2047, "R3 add");
    push_sample(2047, "R3 add max");
    push_sample(-2048, "R3 add");
    push_sample(-2048, "R3 add min");
    push_sample(7, "R7 reverse current");
    cfg_write(0, 7);
    push_sample(2047, "R3 sub");
    push_sample(-2048, "R3 sub min");
    push_sample(3, "R3 sub");
    idle(3);
    // R2 hold while idle
    check(out_valid == 1'b0 && $signed(out_sum) == last_exp, "R2 hold",
          int'($signed(out_sum)), last_exp);

    cfg_write(0, 2);
    push_sample(5, "R4 pass A only");
    push_sample(9, "R4 pass A only");
    cfg_write(0, 4);
    push_sample(11, "R5 pass B only");
    push_sample(12, "R5 pass B only");
    cfg_write(0, 0);
    push_sample(13, "R4 R5 both gated");
    cfg_write(0, 6);

    cfg_write(1, 4 << 1);
    for (int i = 1; i <= 12; i++) push_sample(i * 3 - 20, "R6 length 5");
    cfg_write(1, 15 << 1);
    for (int i = 0; i < 20; i++) push_sample(i * 37 - 300, "R6 length 16");
    cfg_write(1, 64 | (2 << 1));
    for (int i = 0; i < 6; i++) push_sample(i * 11 + 4, "R7 reversal off");
    cfg_write(1, 32 | (3 << 1));
    for (int i = 0; i < 10; i++) push_sample(i * 5 + 1, "R8 odd taps");
    cfg_write(1, 32 | (3 << 1) | 1);
    for (int i = 0; i < 10; i++) push_sample(i * 7 - 30, "R9 interleave odd");
    cfg_write(1, (3 << 1) | 1);
    for (int i = 0; i < 6; i++) push_sample(i + 40, "R9 interleave even");
    cfg_write(1, 32 | (3 << 1));
    push_sample(21, "R10 before restart");
    push_sample(22, "R10 before restart");
    cfg_write(1, 32 | (3 << 1));
    for (int i = 0; i < 5; i++) push_sample(i * 2 + 50, "R10 after restart");
    idle(4);
    check(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule